// File: doc/BRIEF.md
# Equivalent-Time Repetitive Waveform Capture Controller

This controller digitizes a repeating analog signal with nothing more than a single comparator bit and a slowly stepped reference code. It runs one pass of the signal for each reference level. Before the first pass it drives the full-scale code and waits for the filtered reference to settle. Each pass starts on an edge of a trigger that repeats with the signal. During the pass the controller looks at the comparator at a fixed number of evenly spaced instants. At each instant where the reference is above the input, it writes the present code into the record word for that instant.

After a pass the code drops by one step and the controller waits a short settling time before it waits for the next trigger. The code-zero pass is the last one. Because the sweep runs downward, each word ends up holding the lowest code that still exceeded the signal at its instant. A host starts a capture, waits for the done pulse, and then reads the record through a registered read port.

Top module: `rep_capture_ctrl`

## Requirements
- R1: After reset, busy and done are low and dac_code is 0. While busy is low, dac_code stays 0.
- R2: A start pulse while idle clears every record word to 0, raises busy in the next cycle and drives dac_code to the full-scale code. The full-scale code is set by res_sel: 0 gives 63, 1 gives 127, and 2 or 3 give 255. That code is held through the initial settling period.
- R3: A pass begins only on a trigger edge, after both the trigger and the comparator have been resynchronized by two flops. trig_pol = 1 selects the rising edge and trig_pol = 0 selects the falling edge.
- R4: Sample k of a pass (k = 0 to NPTS-1) is taken k × interval cycles after the pass begins. The interval is IVL0, IVL1, IVL2 or IVL3 for ivl_sel = 0, 1, 2 or 3, latched at start.
- R5: At each sample, cmp_hi = 1 means the reference is above the input, and the current code is then written to word k. When cmp_hi = 0, word k is left unchanged. The final word k equals w+1 when the signal level w at that instant is below full scale, and equals 0 otherwise.
- R6: After each pass that is not the last, dac_code decreases by exactly 1. The controller then waits STEP_SETTLE_CYC cycles before a trigger can begin the next pass. The pass at code 0 ends the capture.
- R7: When the code-0 pass ends, done is high for exactly one cycle. In that same cycle busy falls and dac_code returns to 0.
- R8: rd_data presents record word rd_addr one cycle after rd_addr is applied.
- R9: A start pulse while busy is ignored. The running sweep continues without reloading its code.
- R10: Every new capture starts from a cleared record, so no word keeps a value from an earlier capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a capture (sampled while idle) |
| trig_in | input | 1 | Asynchronous trigger related to the repeating signal |
| trig_pol | input | 1 | 1: rising trigger edge, 0: falling |
| cmp_hi | input | 1 | Asynchronous comparator result, 1 = reference above input |
| res_sel | input | 2 | Resolution: 0 = 6 bits, 1 = 7 bits, 2/3 = 8 bits |
| ivl_sel | input | 2 | Sample interval selector |
| rd_addr | input | ADDR_W | Record read address |
| dac_code | output | CODE_W | Reference DAC code |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle pulse at the end of a capture |
| rd_data | output | CODE_W | Registered record word |

## Verification
The bench drives a behavioural comparator that tests the live dac_code against a synthetic signal held constant over each sample slot, timed from the raw trigger edge. A design that samples against the wrong trigger edge reads slots half a period away. A design that uses the wrong interval reads the wrong slot. In both cases the record disagrees with the expected w+1 values. Every pattern places one slot at full scale and expects a zero word there; a sweep that starts one code low, or writes on the wrong comparator sense, breaks that word. A capture of an all-full-scale signal that follows a ramp capture catches a record that is not cleared. A start pulse mid-sweep catches a controller that restarts instead of ignoring it. The bench also checks that done is a single cycle and that busy and dac_code return to idle values.

// File: rtl/rep_capture_pkg.sv
package rep_capture_pkg;

   typedef enum logic [2:0] {
      CAP_IDLE,
      CAP_INIT,
      CAP_ARM,
      CAP_SAMPLE,
      CAP_STEP
   } cap_state_e;

   localparam int unsigned LEVEL_BITS_MIN = 6;
   localparam int unsigned LEVEL_BITS_MAX = 8;

   // resolution selector to number of reference bits
   function automatic int unsigned level_bits(input logic [1:0] sel);
      int unsigned b;
      b = LEVEL_BITS_MIN + int'(sel);
      if (b > LEVEL_BITS_MAX) b = LEVEL_BITS_MAX;
      return b;
   endfunction

   function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rc_sync2.sv
module rc_sync2 #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic meta_q;
         logic stab_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= 1'b0;
               stab_q <= 1'b0;
            end else begin
               meta_q <= d_async[b];
               stab_q <= meta_q;
            end
         end
         assign q_sync[b] = stab_q;
      end
   endgenerate
endmodule

// File: rtl/rc_edge_det.sv
module rc_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic rising,
   output logic hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   assign hit = rising ? (sig & ~prev_q) : (~sig & prev_q);
endmodule

// File: rtl/rc_down_timer.sv
module rc_down_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/rc_pacer.sv
module rc_pacer #(
   parameter int unsigned IVL0 = 10,
   parameter int unsigned IVL1 = 100,
   parameter int unsigned IVL2 = 1000,
   parameter int unsigned IVL3 = 100000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       tick
);
   import rep_capture_pkg::*;

   localparam int unsigned IVL_MAX = max_of2(max_of2(IVL0, IVL1), max_of2(IVL2, IVL3));
   localparam int unsigned CNT_W   = $clog2(IVL_MAX + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wrap_at;

   always_comb begin
      case (sel)
         2'd0:    wrap_at = CNT_W'(IVL0 - 1);
         2'd1:    wrap_at = CNT_W'(IVL1 - 1);
         2'd2:    wrap_at = CNT_W'(IVL2 - 1);
         default: wrap_at = CNT_W'(IVL3 - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart)          cnt_q <= '0;
      else if (cnt_q == wrap_at) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == '0);
endmodule

// File: rtl/rc_sample_mem.sv
module rc_sample_mem #(
   parameter int unsigned DEPTH  = 100,
   parameter int unsigned W      = 8,
   parameter int unsigned AW     = 7,
   parameter bit          RD_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] word_q [DEPTH];
   logic [W-1:0] rd_mux;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              word_q[i] <= '0;
            else if (clr)                            word_q[i] <= '0;
            else if (we && (waddr == AW'(i)))        word_q[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (raddr == AW'(i)) rd_mux = word_q[i];
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         logic [W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/rep_capture_ctrl.sv
module rep_capture_ctrl #(
   parameter int unsigned NPTS            = 100,
   parameter int unsigned CODE_W          = 8,
   parameter int unsigned INIT_SETTLE_CYC = 175000,
   parameter int unsigned STEP_SETTLE_CYC = 31500,
   parameter int unsigned IVL0            = 10,
   parameter int unsigned IVL1            = 100,
   parameter int unsigned IVL2            = 1000,
   parameter int unsigned IVL3            = 100000,
   localparam int unsigned ADDR_W         = $clog2(NPTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              trig_in,
   input  logic              trig_pol,
   input  logic              cmp_hi,
   input  logic [1:0]        res_sel,
   input  logic [1:0]        ivl_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CODE_W-1:0] dac_code,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] rd_data
);
   import rep_capture_pkg::*;

   localparam int unsigned TMR_W = $clog2(max_of2(INIT_SETTLE_CYC, STEP_SETTLE_CYC) + 1);
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NPTS - 1);

   // elaboration-time parameter checks
   generate
      if (NPTS < 2) begin : g_chk_npts
         $error("rep_capture_ctrl: NPTS must be at least 2");
      end
      if (CODE_W < LEVEL_BITS_MAX) begin : g_chk_code
         $error("rep_capture_ctrl: CODE_W too narrow for the finest resolution");
      end
      if ((IVL0 < 2) || (IVL1 < 2) || (IVL2 < 2) || (IVL3 < 2)) begin : g_chk_ivl
         $error("rep_capture_ctrl: every sample interval must be at least 2 cycles");
      end
      if ((INIT_SETTLE_CYC < 1) || (STEP_SETTLE_CYC < 1)) begin : g_chk_settle
         $error("rep_capture_ctrl: settling counts must be nonzero");
      end
   endgenerate

   cap_state_e         state_q;
   logic [CODE_W-1:0]  code_q;
   logic [ADDR_W-1:0]  idx_q;
   logic [1:0]         ivl_q;
   logic               done_q;

   logic [1:0]         sync_q;
   logic               trig_s;
   logic               cmp_s;
   logic               trig_hit;
   logic               tick;
   logic               tmr_exp;
   logic               tmr_load;
   logic [TMR_W-1:0]   tmr_val;
   logic [CODE_W-1:0]  full_scale;
   logic               accept_start;
   logic               pass_end;
   logic               mem_we;

   // both asynchronous inputs share one synchronizer so their latency matches
   rc_sync2 #(.W(2)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({cmp_hi, trig_in}),
      .q_sync  (sync_q)
   );
   assign trig_s = sync_q[0];
   assign cmp_s  = sync_q[1];

   rc_edge_det i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig    (trig_s),
      .rising (trig_pol),
      .hit    (trig_hit)
   );

   rc_pacer #(
      .IVL0 (IVL0),
      .IVL1 (IVL1),
      .IVL2 (IVL2),
      .IVL3 (IVL3)
   ) i_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_q != CAP_SAMPLE),
      .sel     (ivl_q),
      .tick    (tick)
   );

   always_comb begin
      full_scale   = CODE_W'((32'd1 << level_bits(res_sel)) - 32'd1);
      accept_start = (state_q == CAP_IDLE) && start;
      pass_end     = (state_q == CAP_SAMPLE) && tick && (idx_q == LAST_IDX);
      tmr_load     = accept_start || (pass_end && (code_q != '0));
      tmr_val      = accept_start ? TMR_W'(INIT_SETTLE_CYC) : TMR_W'(STEP_SETTLE_CYC);
      mem_we       = (state_q == CAP_SAMPLE) && tick && cmp_s;
   end

   rc_down_timer #(.W(TMR_W)) i_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   rc_sample_mem #(
      .DEPTH  (NPTS),
      .W      (CODE_W),
      .AW     (ADDR_W),
      .RD_REG (1'b1)
   ) i_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept_start),
      .we    (mem_we),
      .waddr (idx_q),
      .wdata (code_q),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAP_IDLE;
         code_q  <= '0;
         idx_q   <= '0;
         ivl_q   <= 2'd0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            CAP_IDLE: begin
               if (start) begin
                  state_q <= CAP_INIT;
                  code_q  <= full_scale;
                  ivl_q   <= ivl_sel;
               end
            end
            CAP_INIT: begin
               if (tmr_exp) state_q <= CAP_ARM;
            end
            CAP_ARM: begin
               if (trig_hit) begin
                  state_q <= CAP_SAMPLE;
                  idx_q   <= '0;
               end
            end
            CAP_SAMPLE: begin
               if (tick) begin
                  if (idx_q == LAST_IDX) begin
                     if (code_q == '0) begin
                        state_q <= CAP_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        code_q  <= code_q - 1'b1;
                        state_q <= CAP_STEP;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            CAP_STEP: begin
               if (tmr_exp) state_q <= CAP_ARM;
            end
            default: state_q <= CAP_IDLE;
         endcase
      end
   end

   assign dac_code = code_q;
   assign busy     = (state_q != CAP_IDLE);
   assign done     = done_q;

endmodule

// File: rtl/rep_capture_ctrl_chk.sv
module rep_capture_ctrl_chk #(
   parameter int unsigned CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [CODE_W-1:0] dac_code
);
   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_code == '0)); // R1

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R2

   AST_CODE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (dac_code != $past(dac_code)))
         |-> (dac_code == $past(dac_code) - CODE_W'(1))); // R6

   AST_LAST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(dac_code) == '0)); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7
endmodule

bind rep_capture_ctrl rep_capture_ctrl_chk #(.CODE_W(CODE_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .dac_code (dac_code)
);

// File: tb/test_rep_capture_ctrl.sv
module test_rep_capture_ctrl;
   localparam int NPTS   = 16;
   localparam int CODE_W = 8;
   localparam int AW     = $clog2(NPTS);
   localparam int IVL_A  = 4;
   localparam int IVL_B  = 5;
   localparam int IVL_C  = 7;
   localparam int IVL_D  = 9;
   localparam int STEP_C = 8;
   localparam int INIT_C = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              trig_in = 1'b0;
   logic              trig_pol = 1'b1;
   logic              cmp_hi;
   logic [1:0]        res_sel = 2'd0;
   logic [1:0]        ivl_sel = 2'd0;
   logic [AW-1:0]     rd_addr = '0;
   logic [CODE_W-1:0] dac_code;
   logic              busy;
   logic              done;
   logic [CODE_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;

   // stimulus state shared with the trigger and comparator model
   int pat_cur = 0;
   int max_cur = 63;
   int ivl_cur = IVL_A;
   int period  = 100;
   int tcyc    = 0;
   bit gen_en  = 1'b0;

   always #2.5 clk = ~clk;

   rep_capture_ctrl #(
      .NPTS            (NPTS),
      .CODE_W          (CODE_W),
      .INIT_SETTLE_CYC (INIT_C),
      .STEP_SETTLE_CYC (STEP_C),
      .IVL0            (IVL_A),
      .IVL1            (IVL_B),
      .IVL2            (IVL_C),
      .IVL3            (IVL_D)
   ) i_rep_capture_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .trig_in  (trig_in),
      .trig_pol (trig_pol),
      .cmp_hi   (cmp_hi),
      .res_sel  (res_sel),
      .ivl_sel  (ivl_sel),
      .rd_addr  (rd_addr),
      .dac_code (dac_code),
      .busy     (busy),
      .done     (done),
      .rd_data  (rd_data)
   );

   // synthetic signal level for slot k; outside the record it reads as 0
   function automatic int wave(input int pat, input int k, input int mx);
      if (k >= NPTS) return 0;
      case (pat)
         0:       return (k * mx) / (NPTS - 1);
         1:       return (k == 3) ? mx : ((k * 29 + 5) % (mx + 1));
         default: return mx;
      endcase
   endfunction

   // behavioural comparator: high when the reference exceeds the signal
   always_comb cmp_hi = (int'(dac_code) > wave(pat_cur, tcyc / ivl_cur, max_cur));

   // repeating trigger, edge at the start of each period
   initial begin
      int pcnt;
      pcnt = 0;
      forever begin
         @(negedge clk);
         if (gen_en) begin
            if (pcnt == 0) begin
               trig_in = trig_pol;
               tcyc = 0;
            end else begin
               tcyc = tcyc + 1;
            end
            if (pcnt == period / 2) trig_in = ~trig_pol;
            pcnt = (pcnt == period - 1) ? 0 : pcnt + 1;
         end else begin
            pcnt = 0;
            tcyc = 1000000;
            trig_in = ~trig_pol;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one full capture followed by a readback of every word
   task automatic run_capture(input int res, input bit pol, input int isel,
                              input int pat, input bit probe, input string tag);
      int ivl_tab[4];
      int guard;
      int c0;
      ivl_tab = '{IVL_A, IVL_B, IVL_C, IVL_D};
      @(negedge clk);
      res_sel  = 2'(res);
      trig_pol = pol;
      ivl_sel  = 2'(isel);
      pat_cur  = pat;
      max_cur  = (res == 0) ? 63 : (res == 1) ? 127 : 255;
      ivl_cur  = ivl_tab[isel];
      period   = NPTS * ivl_cur + 40;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      // R2: full scale loaded, busy raised
      check({tag, " R2 busy"}, int'(busy), 1);
      check({tag, " R2 full-scale code"}, int'(dac_code), max_cur);
      gen_en = 1'b1;
      if (probe) begin
         guard = 0;
         while (int'(dac_code) != max_cur - 3 && guard < 100000) begin
            @(negedge clk);
            guard++;
         end
         c0 = int'(dac_code);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         @(negedge clk);
         // R9: code must not reload to full scale
         checks++;
         if (!(busy && int'(dac_code) <= c0 && int'(dac_code) >= c0 - 1)) begin
            errors++;
            $display("FAIL %s R9: actual code %0d busy %0d expected code %0d or %0d busy 1",
                     tag, dac_code, busy, c0, c0 - 1);
         end
      end
      guard = 0;
      while (!done && guard < 150000) begin
         @(negedge clk);
         guard++;
      end
      check({tag, " R7 done seen"}, int'(done), 1);
      check({tag, " R7 busy low with done"}, int'(busy), 0);
      @(negedge clk);
      gen_en = 1'b0;
      check({tag, " R7 done single cycle"}, int'(done), 0);
      check({tag, " R1 idle code"}, int'(dac_code), 0);
      for (int k = 0; k < NPTS; k++) begin
         int w;
         int e;
         w = wave(pat, k, max_cur);
         e = (w < max_cur) ? w + 1 : 0;
         rd_addr = AW'(k);
         @(negedge clk);
         // R5 word value, R3 edge alignment, R4 interval, R8 read port
         check($sformatf("%s R5 word %0d (R3 R4 R8)", tag, k), int'(rd_data), e);
      end
   endtask

   task automatic test_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 busy after reset", int'(busy), 0);
      check("R1 done after reset", int'(done), 0);
      check("R1 code after reset", int'(dac_code), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic test_six_bit_rising;
      run_capture(0, 1'b1, 0, 0, 1'b0, "six-bit rising ramp");
   endtask

   task automatic test_seven_bit_falling_restart;
      run_capture(1, 1'b0, 2, 1, 1'b1, "seven-bit falling mixed");
   endtask

   task automatic test_eight_bit_slow;
      run_capture(2, 1'b1, 3, 0, 1'b0, "eight-bit rising slow ramp");
   endtask

   task automatic test_clear_between_captures;
      // R10: all-full-scale signal never writes, so every word must read 0
      run_capture(0, 1'b0, 1, 2, 1'b0, "R10 clear after previous capture");
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      test_reset();
      test_six_bit_rising();
      test_seven_bit_falling_restart();
      test_eight_bit_slow();
      test_clear_between_captures();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule